// File: doc/BRIEF.md
# Non-Aborting Bus Grant Bridge

This block sits between a backplane bus-request/bus-acknowledge handshake and a CPU that shares its bus through a multiprocessor arbitration scheme. On that CPU, pulling the priority (enable) input low takes effect at once: a bus cycle that is running is dropped and then retried later. Ordinary peripherals cannot cope with a cycle that is cut off halfway. The bridge makes sure that this abort behaviour is never seen on the backplane.

The external request first passes through a synchroniser. If the CPU is between cycles, the bridge withdraws the CPU's enable and then raises acknowledge on the following clock. If a CPU cycle has already started, the request waits until that cycle has fully finished. A cycle counts as started when the address strobe goes low. It counts as finished once the read or write strobe that follows has returned high. When the requester drops its request, acknowledge falls first, and the CPU gets its enable back a programmable number of clocks later. The backplane has no priority chain.

Top module: `bus_grant_bridge`

## Requirements
- R1: After reset, `cpu_en` is 1 (CPU owns the bus) and `bus_ack` is 0.
- R2: `bus_req` passes through SYNC_STAGES flip-flops (default 2) before it is used. For the first SYNC_STAGES clock edges after `bus_req` changes, neither output changes.
- R3: A request that arrives while no CPU cycle is tracked drops `cpu_en` on clock edge SYNC_STAGES+1 after the change. `bus_ack` rises on the next edge.
- R4: A CPU cycle is in progress from the clock where `ads_n` is 0 until a read or write strobe that was seen low has returned high. During that span, a request leaves `cpu_en` at 1 and `bus_ack` at 0.
- R5: After a held-off request, `cpu_en` stays 1 on the first clock edge after the read strobe returns high. It falls on the second edge, and `bus_ack` rises on the third.
- R6: `bus_ack` is never 1 while `cpu_en` is 1. `bus_ack` rises only after `cpu_en` was already 0 on the previous clock.
- R7: When `bus_req` falls, `bus_ack` falls SYNC_STAGES+1 edges later while `cpu_en` remains 0. `cpu_en` returns to 1 RELEASE_GAP edges after that (default 1).
- R8: If a request is withdrawn while it is waiting for a cycle to end, the bridge goes back to idle. `cpu_en` never falls and `bus_ack` never rises.
- R9: A write strobe (`wds_n`) ends a cycle in the same way as a read strobe.
- R10: `cpu_en` falls only on a clock edge where no CPU cycle was in progress on the previous clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Backplane bus request, active high, asynchronous |
| ads_n | input | 1 | CPU address strobe, active low |
| rds_n | input | 1 | CPU read strobe, active low |
| wds_n | input | 1 | CPU write strobe, active low |
| cpu_en | output | 1 | CPU priority enable input; 0 takes the bus from the CPU |
| bus_ack | output | 1 | Backplane bus acknowledge, active high |

## Verification
The bench targets four situations. The first is a request that arrives while a cycle is open, between the address strobe and the end of the strobe. A design that forwards it would drop `cpu_en` mid-cycle, and that is exactly the abort the block exists to prevent. The second is a request withdrawn while it is still waiting. A design that got this wrong would flash `bus_ack`, or take the bus without need. The third is the order of edges on take and release, because a bridge that switched both outputs in the same clock would acknowledge before the CPU had let go. The fourth is a cycle closed by a write strobe, to catch a tracker that only watches reads and so would wait for ever.

// File: rtl/bus_grant_pkg.sv
package bus_grant_pkg;
   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_WAIT    = 3'd1,
      ST_TAKE    = 3'd2,
      ST_GRANTED = 3'd3,
      ST_RELEASE = 3'd4
   } grant_state_t;
endpackage

// File: rtl/bgb_sync.sv
module bgb_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain_q;

   generate
      if (STAGES < 2) begin : g_bad
         $error("bgb_sync: STAGES must be at least 2");
      end
   endgenerate

   genvar gi;
   generate
      for (gi = 0; gi < STAGES; gi++) begin : g_stage
         if (gi == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[0] <= 1'b0;
               else        chain_q[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[gi] <= 1'b0;
               else        chain_q[gi] <= chain_q[gi-1];
            end
         end
      end
   endgenerate

   assign q = chain_q[STAGES-1];
endmodule

// File: rtl/bgb_cycle_tracker.sv
module bgb_cycle_tracker (
   input  logic clk,
   input  logic rst_n,
   input  logic ads_n,
   input  logic rds_n,
   input  logic wds_n,
   output logic in_cycle
);
   logic busy_q;
   logic seen_q;
   logic strobe_on;

   assign strobe_on = !rds_n || !wds_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         seen_q <= 1'b0;
      end else if (!ads_n) begin
         busy_q <= 1'b1;
         seen_q <= seen_q && busy_q;
      end else if (busy_q) begin
         if (strobe_on)   seen_q <= 1'b1;
         else if (seen_q) begin
            busy_q <= 1'b0;
            seen_q <= 1'b0;
         end
      end
   end

   assign in_cycle = !ads_n || busy_q;

   // R4: an address strobe opens a tracked cycle
   a_r4_strobe_opens: assert property (@(posedge clk) disable iff (!rst_n)
      !ads_n |=> busy_q);

   // R5: a cycle closes only once the data strobe has been seen and released
   a_r5_close_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_q) |-> $past(seen_q) && $past(!strobe_on));
endmodule

// File: rtl/bgb_grant_fsm.sv
module bgb_grant_fsm
   import bus_grant_pkg::*;
#(
   parameter int RELEASE_GAP = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_sync,
   input  logic in_cycle,
   output logic cpu_en,
   output logic bus_ack
);
   localparam int GAP_W = (RELEASE_GAP > 1) ? $clog2(RELEASE_GAP + 1) : 1;

   generate
      if (RELEASE_GAP < 1) begin : g_bad
         $error("bgb_grant_fsm: RELEASE_GAP must be at least 1");
      end
   endgenerate

   grant_state_t state_q, state_d;
   logic         gap_done;

   generate
      if (RELEASE_GAP == 1) begin : g_gap_one
         assign gap_done = 1'b1;
      end else begin : g_gap_cnt
         logic [GAP_W-1:0] gap_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                        gap_q <= '0;
            else if (state_q != ST_RELEASE)    gap_q <= GAP_W'(RELEASE_GAP - 1);
            else if (gap_q != '0)              gap_q <= gap_q - 1'b1;
         end
         assign gap_done = (gap_q == '0);
      end
   endgenerate

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:    if (req_sync) state_d = in_cycle ? ST_WAIT : ST_TAKE;
         ST_WAIT:    if (!req_sync)     state_d = ST_IDLE;
                     else if (!in_cycle) state_d = ST_TAKE;
         ST_TAKE:    state_d = req_sync ? ST_GRANTED : ST_IDLE;
         ST_GRANTED: if (!req_sync) state_d = ST_RELEASE;
         ST_RELEASE: if (gap_done)  state_d = ST_IDLE;
         default:    state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   assign cpu_en  = (state_q == ST_IDLE) || (state_q == ST_WAIT);
   assign bus_ack = (state_q == ST_GRANTED);

   // R10: the CPU enable is never withdrawn while a cycle is open
   a_r10_no_abort: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cpu_en) |-> $past(!in_cycle));

   // R8: a withdrawn waiting request returns to idle
   a_r8_withdraw: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_WAIT && !req_sync) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/bus_grant_bridge.sv
module bus_grant_bridge #(
   parameter int SYNC_STAGES = 2,
   parameter int RELEASE_GAP = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bus_req,
   input  logic ads_n,
   input  logic rds_n,
   input  logic wds_n,
   output logic cpu_en,
   output logic bus_ack
);
   logic req_sync;
   logic in_cycle;

   bgb_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (bus_req),
      .q     (req_sync)
   );

   bgb_cycle_tracker u_track (
      .clk      (clk),
      .rst_n    (rst_n),
      .ads_n    (ads_n),
      .rds_n    (rds_n),
      .wds_n    (wds_n),
      .in_cycle (in_cycle)
   );

   bgb_grant_fsm #(.RELEASE_GAP(RELEASE_GAP)) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_sync (req_sync),
      .in_cycle (in_cycle),
      .cpu_en   (cpu_en),
      .bus_ack  (bus_ack)
   );

   // R6: acknowledge rises only after the CPU has already been disabled
   a_r6_ack_after_take: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_ack) |-> $past(!cpu_en) && !cpu_en);

   // R7: the CPU enable returns only after acknowledge has dropped
   a_r7_ack_before_enable: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cpu_en) |-> $past(!bus_ack) && !bus_ack);
endmodule

// File: tb/bus_grant_bridge_bench.sv
module bus_grant_bridge_bench;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bus_req = 1'b0;
   logic ads_n = 1'b1;
   logic rds_n = 1'b1;
   logic wds_n = 1'b1;
   logic cpu_en;
   logic bus_ack;
   int   checks = 0;
   int   fails = 0;

   always #2 clk = ~clk;

   bus_grant_bridge u_bus_grant_bridge (
      .clk(clk), .rst_n(rst_n), .bus_req(bus_req),
      .ads_n(ads_n), .rds_n(rds_n), .wds_n(wds_n),
      .cpu_en(cpu_en), .bus_ack(bus_ack)
   );

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic check(input string req, input logic en_exp, input logic ack_exp);
      checks++;
      if (cpu_en !== en_exp || bus_ack !== ack_exp) begin
         fails++;
         $display("FAIL %s: cpu_en=%b bus_ack=%b expected cpu_en=%b bus_ack=%b",
                  req, cpu_en, bus_ack, en_exp, ack_exp);
      end
   endtask

   task automatic t_reset;
      rst_n = 1'b0;
      tick(2);
      check("R1 reset", 1'b1, 1'b0);
      rst_n = 1'b1;
      tick(2);
      check("R1 after reset", 1'b1, 1'b0);
   endtask

   task automatic t_idle_grant;
      bus_req = 1'b1;
      tick(2);
      check("R2 sync latency", 1'b1, 1'b0);
      tick(1);
      check("R3 enable drops first", 1'b0, 1'b0);
      tick(1);
      check("R3 R6 ack rises", 1'b0, 1'b1);
      bus_req = 1'b0;
      tick(2);
      check("R2 release latency", 1'b0, 1'b1);
      tick(1);
      check("R7 ack drops first", 1'b0, 1'b0);
      tick(1);
      check("R7 enable restored", 1'b1, 1'b0);
   endtask

   task automatic t_busy_grant(input bit use_write, input string tag);
      ads_n = 1'b0;
      tick(1);
      ads_n = 1'b1;
      if (use_write) wds_n = 1'b0; else rds_n = 1'b0;
      bus_req = 1'b1;
      tick(6);
      check({tag, " R4 held off"}, 1'b1, 1'b0);
      rds_n = 1'b1;
      wds_n = 1'b1;
      tick(1);
      check({tag, " R5 still enabled"}, 1'b1, 1'b0);
      tick(1);
      check({tag, " R5 enable drops"}, 1'b0, 1'b0);
      tick(1);
      check({tag, " R5 ack rises"}, 1'b0, 1'b1);
      bus_req = 1'b0;
      tick(3);
      check({tag, " R7 ack drops"}, 1'b0, 1'b0);
      tick(1);
      check({tag, " R7 enable back"}, 1'b1, 1'b0);
   endtask

   task automatic t_withdraw;
      ads_n = 1'b0;
      tick(1);
      ads_n = 1'b1;
      wds_n = 1'b0;
      bus_req = 1'b1;
      tick(4);
      check("R8 waiting", 1'b1, 1'b0);
      bus_req = 1'b0;
      tick(4);
      check("R8 withdrawn", 1'b1, 1'b0);
      wds_n = 1'b1;
      tick(3);
      check("R8 idle after cycle end", 1'b1, 1'b0);
   endtask

   initial begin
      tick(1);
      t_reset();
      t_idle_grant();
      t_busy_grant(1'b0, "read");
      t_busy_grant(1'b1, "R9 write");
      t_withdraw();
      tick(2);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      #800000;
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule